// File: doc/BRIEF.md
# Sequencing Delay Timer Bank

This block supplies the waits that a power-sequencing controller inserts between supply ramp steps. It holds four independent delay timers. All four are paced by one shared tick, which is derived from a chosen source pulse stream through a power-of-two prescaler.

The source is either a 1 MHz reference strobe or the rising edges of an external clock pin, which is synchronised internally. When the external pin drives the timers, every timeout scales with that pin's frequency.

Each timer has a level start input. While start is held, the timer counts ticks. Once its programmed 8-bit count of ticks has passed, it raises and holds an expired flag. Dropping start clears the timer at once. With the 1 MHz reference and prescaler exponents from 5 to 11, one tick lasts from 32 µs to 2.048 ms. A count of 255 therefore reaches about 522 ms.

The interface has no data stream, so every pin is a plain control or status level.

Top module: `seq_delay_timers`

## Requirements
- R1: While `rst_ni` is low, and directly after it is released, every bit of `expired_o` is 0.
- R2: The shared tick fires on every source pulse whose ordinal, counted from 1 since reset, is a multiple of 2^k. Here k is `prescale_exp_i` clamped to the range 5..11, so a setting below 5 acts as 5 and a setting above 11 acts as 11.
- R3: A timer whose count N lies in 1..255 raises `expired_o[i]` on the Nth tick that occurs while its start is high. The flag is visible by the second clock edge after the edge that samples the source pulse. It is never raised on an earlier tick.
- R4: A timer with count 0 behaves as a count of 1 and expires on the first tick after start.
- R5: Once raised, `expired_o[i]` stays 1 for as long as `start_i[i]` stays 1, whatever further ticks arrive.
- R6: A low `start_i[i]` clears `expired_o[i]` and the timer's tick count on the next clock edge. A later start counts from zero again.
- R7: With `use_ext_i` = 1, each rising edge of `ext_clk_i` is one source pulse, and `ref_pulse_i` has no effect. Each level of `ext_clk_i` must be held for at least 3 clock cycles.
- R8: With `use_ext_i` = 0, each clock cycle in which `ref_pulse_i` is high is one source pulse, and `ext_clk_i` has no effect.
- R9: The timers are independent. Timer i uses `start_i[i]` and the count field `count_i[8*i+7:8*i]`, and reports on `expired_o[i]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ref_pulse_i | input | 1 | 1 MHz reference strobe, one cycle wide |
| ext_clk_i | input | 1 | External clock pin, asynchronous |
| use_ext_i | input | 1 | Source select: 1 = external pin, 0 = reference strobe |
| prescale_exp_i | input | 4 | Prescaler exponent k (clamped to 5..11) |
| start_i | input | 4 | Per-timer level start |
| count_i | input | 32 | Four packed 8-bit tick counts |
| expired_o | output | 4 | Per-timer expired flags |

## Verification
The embedded properties take three things for granted. The external pin holds each level for several clock cycles, so a synchronised edge yields a single-cycle pulse. The prescaler exponent never drops below its floor, which keeps ticks at least two cycles apart. A timer's count and the source selection do not change while that timer's start is high. The stimulus follows all three. It holds the external pin for four cycles per level and drives reference strobes one cycle wide. It changes counts, exponents and the source only while every start is low, and it checks the out-of-range exponents only through the clamped behaviour at the ports.

// File: rtl/sdt_pkg.sv
package sdt_pkg;
  localparam int unsigned SDT_TIMERS  = 4;
  localparam int unsigned SDT_CNT_W   = 8;
  localparam int unsigned SDT_EXP_W   = 4;
  localparam int unsigned SDT_MIN_EXP = 5;
  localparam int unsigned SDT_MAX_EXP = 11;
  localparam int unsigned SDT_SYNC    = 2;

  typedef enum logic {
    SRC_REF = 1'b0,
    SRC_EXT = 1'b1
  } sdt_src_e;
endpackage

// File: rtl/sdt_src_select.sv
module sdt_src_select
  import sdt_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = SDT_SYNC
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_pulse_i,
  input  logic ext_clk_i,
  input  logic use_ext_i,
  output logic src_pulse_o
);
  // sync chain plus one extra stage that holds the previous level
  logic [SYNC_STAGES:0] sync_q;
  logic                 ext_rise;
  sdt_src_e             src_sel;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[SYNC_STAGES-1:0], ext_clk_i};
  end

  assign ext_rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];
  assign src_sel  = use_ext_i ? SRC_EXT : SRC_REF;

  always_comb begin
    unique case (src_sel)
      SRC_EXT: src_pulse_o = ext_rise;
      default: src_pulse_o = ref_pulse_i;
    endcase
  end

  // R7: a synchronised edge gives one pulse only
  p_ext_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_rise |=> !ext_rise);
endmodule

// File: rtl/sdt_prescaler.sv
module sdt_prescaler
  import sdt_pkg::*;
#(
  parameter int unsigned EXP_W   = SDT_EXP_W,
  parameter int unsigned MIN_EXP = SDT_MIN_EXP,
  parameter int unsigned MAX_EXP = SDT_MAX_EXP
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic             tick_o
);
  localparam logic [EXP_W-1:0] ExpLo = EXP_W'(MIN_EXP);
  localparam logic [EXP_W-1:0] ExpHi = EXP_W'(MAX_EXP);

  logic [MAX_EXP-1:0] ord_q;
  logic [MAX_EXP-1:0] mask_c;
  logic [EXP_W-1:0]   exp_c;
  logic               tick_q;

  always_comb begin
    if (exp_i < ExpLo)      exp_c = ExpLo;
    else if (exp_i > ExpHi) exp_c = ExpHi;
    else                    exp_c = exp_i;
    mask_c = ~({MAX_EXP{1'b1}} << exp_c);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ord_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= pulse_i && ((ord_q & mask_c) == mask_c);
      if (pulse_i) ord_q <= ord_q + 1'b1;
    end
  end

  assign tick_o = tick_q;

  // R2: a tick always follows a source pulse
  p_tick_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |-> $past(pulse_i));
  // R2: the divisor floor keeps ticks apart
  p_tick_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_q |=> !tick_q);
endmodule

// File: rtl/sdt_timer.sv
module sdt_timer
  import sdt_pkg::*;
#(
  parameter int unsigned CNT_W = SDT_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] elapsed_q;
  logic [CNT_W:0]   next_c;
  logic [CNT_W:0]   target_c;
  logic             expired_q;

  assign next_c   = {1'b0, elapsed_q} + 1'b1;
  assign target_c = (count_i == '0) ? (CNT_W+1)'(1) : {1'b0, count_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      elapsed_q <= '0;
      expired_q <= 1'b0;
    end else if (!start_i) begin
      elapsed_q <= '0;
      expired_q <= 1'b0;
    end else if (tick_i && !expired_q) begin
      elapsed_q <= next_c[CNT_W-1:0];
      if (next_c >= target_c) expired_q <= 1'b1;
    end
  end

  assign expired_o = expired_q;

  // R6: a dropped start clears the flag on the next edge
  p_clear_on_stop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !expired_q);
  // R5: the flag holds while start is held
  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expired_q && start_i) |=> expired_q);
  // R3: the flag rises only on a tick
  p_rise_on_tick_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(expired_q) |-> $past(tick_i));
endmodule

// File: rtl/seq_delay_timers.sv
module seq_delay_timers
  import sdt_pkg::*;
#(
  parameter int unsigned NUM_TIMERS  = SDT_TIMERS,
  parameter int unsigned CNT_W       = SDT_CNT_W,
  parameter int unsigned EXP_W       = SDT_EXP_W,
  parameter int unsigned MIN_EXP     = SDT_MIN_EXP,
  parameter int unsigned MAX_EXP     = SDT_MAX_EXP,
  parameter int unsigned SYNC_STAGES = SDT_SYNC
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        ref_pulse_i,
  input  logic                        ext_clk_i,
  input  logic                        use_ext_i,
  input  logic [EXP_W-1:0]            prescale_exp_i,
  input  logic [NUM_TIMERS-1:0]       start_i,
  input  logic [NUM_TIMERS*CNT_W-1:0] count_i,
  output logic [NUM_TIMERS-1:0]       expired_o
);
  logic src_pulse;
  logic tick;

  sdt_src_select #(.SYNC_STAGES(SYNC_STAGES)) u_src (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ref_pulse_i (ref_pulse_i),
    .ext_clk_i   (ext_clk_i),
    .use_ext_i   (use_ext_i),
    .src_pulse_o (src_pulse)
  );

  sdt_prescaler #(.EXP_W(EXP_W), .MIN_EXP(MIN_EXP), .MAX_EXP(MAX_EXP)) u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pulse_i (src_pulse),
    .exp_i   (prescale_exp_i),
    .tick_o  (tick)
  );

  for (genvar gi = 0; gi < NUM_TIMERS; gi++) begin : g_tmr
    sdt_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_i    (tick),
      .start_i   (start_i[gi]),
      .count_i   (count_i[gi*CNT_W +: CNT_W]),
      .expired_o (expired_o[gi])
    );
  end
endmodule

// File: tb/seq_delay_timers_bench.sv
module seq_delay_timers_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ref_p = 1'b0;
  logic        ext = 1'b0;
  logic        use_ext = 1'b0;
  logic [3:0]  kset = 4'd5;
  logic [3:0]  start = 4'd0;
  logic [31:0] counts = '0;
  logic [3:0]  expired;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int gcount = 0;
  int tcnt [4];

  always #10 clk = ~clk;

  seq_delay_timers u_seq_delay_timers (
    .clk_i(clk), .rst_ni(rst_n), .ref_pulse_i(ref_p), .ext_clk_i(ext),
    .use_ext_i(use_ext), .prescale_exp_i(kset), .start_i(start),
    .count_i(counts), .expired_o(expired)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual cycles %0d expected below 190000", cyc);
      summary();
    end
  end

  function automatic int eff_k();
    if (kset < 5) return 5;
    if (kset > 11) return 11;
    return int'(kset);
  endfunction

  function automatic logic [3:0] model();
    logic [3:0] e;
    for (int i = 0; i < 4; i++) begin
      int n = int'(counts[i*8 +: 8]);
      if (n == 0) n = 1;
      e[i] = start[i] && (tcnt[i] >= n);
    end
    return e;
  endfunction

  task automatic check(string tag);
    logic [3:0] e = model();
    n_chk++;
    if (expired !== e) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b (pulse %0d)", tag, expired, e, gcount);
    end
  endtask

  // one source pulse on the selected source, then settle and check
  task automatic pulse(string tag);
    if (use_ext) begin
      ext = 1'b1; repeat (4) @(negedge clk);
      ext = 1'b0; repeat (4) @(negedge clk);
    end else begin
      ref_p = 1'b1; @(negedge clk);
      ref_p = 1'b0; repeat (4) @(negedge clk);
    end
    gcount++;
    if (gcount % (1 << eff_k()) == 0)
      for (int i = 0; i < 4; i++) if (start[i]) tcnt[i]++;
    check(tag);
  endtask

  task automatic go(logic [3:0] s);
    start = s;
    for (int i = 0; i < 4; i++) tcnt[i] = 0;
    @(negedge clk);
  endtask

  task automatic stop(string tag);
    start = 4'd0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) tcnt[i] = 0;
    check(tag);
  endtask

  // run until the largest effective count has passed by one tick
  task automatic run_all(int max_n, string tag);
    while (tcnt[0] <= max_n && tcnt[1] <= max_n &&
           tcnt[2] <= max_n && tcnt[3] <= max_n) pulse(tag);
  endtask

  initial begin
    for (int i = 0; i < 4; i++) tcnt[i] = 0;
    start = 4'hF; counts = {8'd1, 8'd1, 8'd1, 8'd1};
    repeat (3) @(negedge clk);
    check("R1 in reset");
    start = 4'd0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset");

    // R3 R4 R9: distinct counts per timer across exponents
    for (int k = 5; k <= 7; k++) begin
      kset = 4'(k);
      counts = {8'd7, 8'd3, 8'd1, 8'd0};
      go(4'hF);
      run_all(7, "R3 R4 R9 sweep");
      repeat (3) pulse("R5 hold");
      stop("R6 clear");
    end

    // R9: only some timers started
    kset = 4'd5;
    counts = {8'd2, 8'd2, 8'd2, 8'd2};
    go(4'b0101);
    run_all(2, "R9 partial start");
    stop("R6 clear partial");

    // R6: restart counts afresh
    counts = {8'd3, 8'd3, 8'd3, 8'd3};
    go(4'hF);
    repeat (40) pulse("R6 first run");
    stop("R6 stop mid");
    go(4'hF);
    run_all(3, "R6 restart");
    stop("R6 clear");

    // R3: full-range count
    counts = {8'd255, 8'd254, 8'd128, 8'd0};
    go(4'hF);
    while (tcnt[3] <= 255) pulse("R3 max count");
    stop("R6 clear max");

    // R2: clamping of the exponent
    counts = {8'd1, 8'd1, 8'd1, 8'd1};
    kset = 4'd2;
    go(4'hF);
    run_all(1, "R2 clamp low");
    stop("R6 clear");
    kset = 4'd13;
    go(4'hF);
    run_all(1, "R2 clamp high");
    stop("R6 clear");

    // R7: external source, reference ignored
    kset = 4'd5;
    use_ext = 1'b1;
    @(negedge clk);
    counts = {8'd4, 8'd2, 8'd1, 8'd0};
    go(4'hF);
    run_all(4, "R7 external");
    stop("R6 clear");
    go(4'hF);
    for (int p = 0; p < 80; p++) begin
      ref_p = 1'b1; @(negedge clk);
      ref_p = 1'b0; @(negedge clk);
    end
    repeat (3) @(negedge clk);
    check("R7 reference ignored");
    stop("R6 clear");

    // R8: reference source, external pin ignored
    use_ext = 1'b0;
    @(negedge clk);
    go(4'hF);
    for (int p = 0; p < 80; p++) begin
      ext = 1'b1; repeat (4) @(negedge clk);
      ext = 1'b0; repeat (4) @(negedge clk);
    end
    check("R8 external ignored");
    run_all(4, "R8 reference");
    stop("R6 clear");

    summary();
  end
endmodule